// File: doc/BRIEF.md
# Serial Clock-Enable Configuration Slave

This block is a write-only slave on a two-wire serial bus. It holds the enable mask for a fan-out of thirteen clock outputs. A bus master writes the mask. Each output carries a buffered reference clock when its enable bit is set. It is held low when its bit is clear. A separate test input releases every output to high impedance, whatever the mask holds.

The bus pins are sampled in the system clock domain. Each pin passes through a two-flop synchronizer and then an edge detector. The slave answers only to its own 7-bit address with the write direction. Every write carries two header bytes, a command code and a byte count. The slave acknowledges both header bytes and discards their contents. The bytes that follow go, in fixed order, into configuration byte 0, then byte 1, then byte 2. There is no register pointer, so a master that wants to change a later byte must also resend every byte before it. Bytes after the third are acknowledged and dropped.

Each enable bit reaches its output only on a falling edge of the reference clock. Turning an output on or off therefore never cuts a high phase short.

Top module: `clkgate_cfg_slave`

## Requirements
- R1: The address byte 8'hD2 (address 1101001, direction bit 0) is acknowledged.
- R2: A falling SDA while SCL is high (START) restarts reception at the address byte. This applies even in the middle of a transfer. A rising SDA while SCL is high (STOP) ends the transfer and releases SDA.
- R3: The slave acknowledges an accepted byte by pulling SDA low for the ninth SCL pulse, starting while SCL is low. It releases SDA after that pulse.
- R4: The two bytes after the address are acknowledged, and their values do not affect the enable mask.
- R5: The data bytes are stored in arrival order. Byte 0 bits 7..0 enable outputs 7..0. Byte 1 bits 2..0 enable outputs 12..10, and its bits 7..3 are ignored. Byte 2 bits 7..6 enable outputs 9..8, and its bits 5..0 are ignored. A 1 means enabled. A transfer that ends early leaves the bytes it did not reach unchanged.
- R6: Data bytes after the third are acknowledged and have no effect on the mask.
- R7: Reset sets the enable mask to 13'h1FFF, so every output is on.
- R8: An address byte other than 8'hD2 is not acknowledged. This includes the read form 8'hD3. All bytes after it are ignored and not acknowledged until the next START.
- R9: An output carries the reference clock when its enable bit is 1 and is held low when the bit is 0. A change of the mask takes effect at a falling edge of the reference clock.
- R10: While `test_hiz` is 1, `clk_out_oe` is 0, so every output is released to high impedance. Otherwise `clk_out_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| ref_clk | input | 1 | Buffered reference clock to be fanned out |
| test_hiz | input | 1 | 1 releases all outputs to high impedance |
| en_mask | output | 13 | Stored enable mask, bit n for output n |
| clk_out | output | 13 | Gated reference clock per output |
| clk_out_oe | output | 1 | Output driver enable for all 13 outputs |

## Verification
The assertions assume that the bus stays legal. SDA changes only while SCL is low, except at START and STOP. Every SCL level lasts several system clocks, so the synchronized copies of SCL and SDA keep their order of events. Under that assumption the slave can pull SDA only while SCL is low and must have let it go after a STOP.

The bench master holds each SCL phase for ten system clocks. It moves SDA five clocks after SCL falls and at no other time, apart from START and STOP. The bus is modelled as a wired-AND of master and slave, so the bench reads the acknowledge from the shared line exactly as a real master would.

// File: rtl/clkgate_cfg_slave.sv
`timescale 1ns/1ps
module clkgate_cfg_slave #(
  parameter logic [6:0] DEV_ADDR = 7'b1101001,
  parameter int         SYNC_LEN = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic        ref_clk,
  input  logic        test_hiz,
  output logic [12:0] en_mask,
  output logic [12:0] clk_out,
  output logic        clk_out_oe
);
  localparam int NOUT = 13;
  localparam logic [7:0] ADDR_WR = {DEV_ADDR, 1'b0};
  localparam logic [2:0] IDX_LAST = 3'd6;

  typedef enum logic [1:0] {S_IDLE, S_RX, S_ACK} st_t;

  logic [SYNC_LEN-1:0] scl_sy, sda_sy;
  logic scl_s, sda_s, scl_p, sda_p;
  logic start, stop, scl_rise, scl_fall;
  st_t st;
  logic [3:0] bitcnt;
  logic [2:0] byte_idx;
  logic [7:0] shreg;
  logic [7:0] b0;
  logic [2:0] b1;
  logic [1:0] b2;
  logic [NOUT-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC_LEN-2:0], scl_i};
      sda_sy <= {sda_sy[SYNC_LEN-2:0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end

  assign scl_s    = scl_sy[SYNC_LEN-1];
  assign sda_s    = sda_sy[SYNC_LEN-1];
  assign start    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop     = scl_s & scl_p & ~sda_p & sda_s;
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= S_IDLE;
      bitcnt   <= '0;
      byte_idx <= '0;
      shreg    <= '0;
      sda_oe   <= 1'b0;
      b0       <= 8'hFF;
      b1       <= 3'b111;
      b2       <= 2'b11;
    end else if (start) begin
      st       <= S_RX;
      bitcnt   <= '0;
      byte_idx <= '0;
      sda_oe   <= 1'b0;
    end else if (stop) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_RX: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            if (byte_idx != 3'd0 || shreg == ADDR_WR) begin
              sda_oe <= 1'b1;
              st     <= S_ACK;
              case (byte_idx)
                3'd3:    b0 <= shreg;
                3'd4:    b1 <= shreg[2:0];
                3'd5:    b2 <= shreg[7:6];
                default: ;
              endcase
            end else begin
              st <= S_IDLE;
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            st     <= S_RX;
            if (byte_idx != IDX_LAST) byte_idx <= byte_idx + 3'd1;
          end
        end
        default: ;
      endcase
    end

  assign en_mask = {b1, b2, b0};

  always_ff @(negedge ref_clk or negedge rst_n)
    if (!rst_n) en_q <= '1;
    else        en_q <= en_mask;

  assign clk_out    = {NOUT{ref_clk}} & en_q;
  assign clk_out_oe = ~test_hiz;
endmodule

module clkgate_cfg_slave_chk #(
  parameter logic [6:0] DEV_ADDR = 7'b1101001
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        stop,
  input logic        scl_s,
  input logic        scl_fall,
  input logic        sda_oe,
  input logic [2:0]  byte_idx,
  input logic [3:0]  bitcnt,
  input logic [7:0]  shreg,
  input logic [12:0] en_mask
);
  assert_addr_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && byte_idx == 3'd0) |-> shreg == {DEV_ADDR, 1'b0});
  assert_start_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (bitcnt == 4'd0 && byte_idx == 3'd0 && !sda_oe));
  assert_stop_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !sda_oe);
  assert_ack_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  assert_ack_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> ($past(scl_fall) || $past(start) || $past(stop)));
  assert_mask_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en_mask) |-> $past(scl_fall));
endmodule

bind clkgate_cfg_slave clkgate_cfg_slave_chk #(.DEV_ADDR(DEV_ADDR)) u_chk (.*);

// File: tb/test_clkgate_cfg_slave.sv
`timescale 1ns/1ps
module test_clkgate_cfg_slave;
  localparam int Q = 5;
  logic clk = 0, rst_n = 0, ref_clk = 0, test_hiz = 0;
  logic scl_m = 1, sda_m = 1;
  logic sda_oe, clk_out_oe;
  logic [12:0] en_mask, clk_out;
  logic sda_line;
  int nchk = 0, nfail = 0;
  logic [7:0] m0 = 8'hFF, m1 = 8'hFF, m2 = 8'hFF;

  always #10 clk = ~clk;
  always #15 ref_clk = ~ref_clk;
  assign sda_line = sda_m & ~sda_oe;

  clkgate_cfg_slave i_clkgate_cfg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .ref_clk(ref_clk), .test_hiz(test_hiz), .en_mask(en_mask),
    .clk_out(clk_out), .clk_out_oe(clk_out_oe));

  function automatic logic [12:0] exp_mask(input logic [7:0] a, b, c);
    return {b[2:0], c[7:6], a};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic i2c_start;
    sda_m = 1; scl_m = 1; hc(Q);
    sda_m = 0; hc(Q);
    scl_m = 0; hc(Q);
  endtask

  task automatic i2c_stop;
    sda_m = 0; hc(Q);
    scl_m = 1; hc(Q);
    sda_m = 1; hc(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hc(Q);
      scl_m = 1; hc(2*Q);
      scl_m = 0; hc(Q);
    end
    sda_m = 1; hc(Q);
    scl_m = 1; hc(Q);
    @(negedge clk); ack = !sda_line;
    hc(Q);
    scl_m = 0; hc(Q);
  endtask

  task automatic xfer(input logic [7:0] addr, h1, h2, input int n,
                      input logic [7:0] d [4], output int acks);
    bit a;
    acks = 0;
    i2c_start;
    send_byte(addr, a); acks += int'(a);
    send_byte(h1, a);   acks += int'(a);
    send_byte(h2, a);   acks += int'(a);
    for (int i = 0; i < n; i++) begin send_byte(d[i], a); acks += int'(a); end
    i2c_stop;
    @(negedge clk);
  endtask

  task automatic gate_chk(input string req);
    repeat (3) @(posedge ref_clk);
    #5 chk(req, 32'(clk_out), 32'(en_mask));
    @(negedge ref_clk);
    #5 chk(req, 32'(clk_out), 32'h0);
  endtask

  initial begin
    #(20ns * 200000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] d [4];
    int acks;
    bit a;
    hc(4); rst_n = 1; @(negedge clk);
    chk("R7 reset mask", 32'(en_mask), 32'h1FFF);
    chk("R3 idle sda", 32'(sda_oe), 0);
    chk("R10 oe idle", 32'(clk_out_oe), 1);
    gate_chk("R9 gate reset");

    for (int k = 0; k < 16; k++) begin
      d[0] = 8'(k * 16 + (15 - k)); d[1] = 8'(k * 37); d[2] = 8'(k * 73); d[3] = 0;
      xfer(8'hD2, 8'(k * 11), 8'(~k), 3, d, acks);
      m0 = d[0]; m1 = d[1]; m2 = d[2];
      chk("R1 R3 R4 acks", 32'(acks), 6);
      chk("R5 R4 mask", 32'(en_mask), 32'(exp_mask(m0, m1, m2)));
      if (k % 4 == 0) gate_chk("R9 gate sweep");
    end

    d[0] = 8'h3C; d[1] = 8'h00; d[2] = 8'h00; d[3] = 0;
    xfer(8'hD2, 8'h00, 8'h00, 1, d, acks);
    m0 = 8'h3C;
    chk("R5 partial acks", 32'(acks), 4);
    chk("R5 partial mask", 32'(en_mask), 32'(exp_mask(m0, m1, m2)));

    d[0] = 8'hA5; d[1] = 8'hFA; d[2] = 8'h40; d[3] = 8'h00;
    xfer(8'hD2, 8'hFF, 8'h03, 4, d, acks);
    m0 = 8'hA5; m1 = 8'hFA; m2 = 8'h40;
    chk("R6 extra acks", 32'(acks), 7);
    chk("R6 extra mask", 32'(en_mask), 32'(exp_mask(m0, m1, m2)));

    d[0] = 8'h00; d[1] = 8'h00; d[2] = 8'h00; d[3] = 0;
    xfer(8'hD4, 8'h00, 8'h00, 3, d, acks);
    chk("R8 wrong addr acks", 32'(acks), 0);
    chk("R8 wrong addr mask", 32'(en_mask), 32'(exp_mask(m0, m1, m2)));
    xfer(8'hD3, 8'h00, 8'h00, 3, d, acks);
    chk("R8 read acks", 32'(acks), 0);
    chk("R8 read mask", 32'(en_mask), 32'(exp_mask(m0, m1, m2)));

    i2c_start;
    send_byte(8'hD2, a); send_byte(8'h01, a); send_byte(8'h02, a);
    send_byte(8'h55, a);
    i2c_start;
    send_byte(8'hD2, a);
    chk("R2 restart addr ack", 32'(a), 1);
    send_byte(8'h77, a); send_byte(8'h88, a);
    send_byte(8'hC3, a);
    i2c_stop; @(negedge clk);
    m0 = 8'hC3;
    chk("R2 restart mask", 32'(en_mask), 32'(exp_mask(m0, m1, m2)));
    chk("R2 stop release", 32'(sda_oe), 0);
    gate_chk("R9 gate final");

    test_hiz = 1; @(negedge clk);
    chk("R10 hiz", 32'(clk_out_oe), 0);
    test_hiz = 0; @(negedge clk);
    chk("R10 drive", 32'(clk_out_oe), 1);

    rst_n = 0; hc(2); rst_n = 1; @(negedge clk);
    chk("R7 re-reset mask", 32'(en_mask), 32'h1FFF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule